// File: doc/BRIEF.md
# Paired Transmit/Receive Word FIFO with Wrapping Occupancy

This block holds the word buffers of a serial controller: one queue of words waiting to be shifted out and one queue of words that have been shifted in. Each queue keeps eight words of nine bits. The register side pushes transmit words and pops received words. The shift engine pops transmit words and pushes received words. Each queue reports its fill level in a three-bit field, together with threshold flags, and all of these are registered.

The fill field has only three bits, so it reads zero both when a queue is empty and when it holds eight words. For the transmit queue, a separate empty flag and a separate full flag tell these two cases apart. For the receive queue, a receive-ready flag marks the full case.

A soft-reset request empties both queues in one cycle, but only when the receive queue is empty. If the receive queue still holds data, the request is refused and a one-cycle busy-error pulse is raised.

Top module: `sfp_fifo_pair`

## Requirements
- R1: Each queue returns its words in the order they were pushed. Read data is registered: the word removed by a pop at a clock edge appears on the read-data port after that edge and stays there until the next accepted pop.
- R2: The level output of each queue equals its word count modulo 8, so it reads 0 when the queue holds 8 words.
- R3: The receive-ready flag is 1 exactly when the receive queue holds 8 words.
- R4: The transmit full flag is 1 exactly when the transmit queue holds 8 words. The transmit empty flag is 1 exactly when it holds 0 words.
- R5: The half flag of each queue is 1 exactly when that queue holds 4 or more words.
- R6: A push into a full queue is dropped, including when a pop on the same queue is accepted in that cycle. A pop from an empty queue leaves the count and the read data unchanged, and a push in the same cycle is still accepted.
- R7: While a queue's enable input is 0, its push and pop strobes are ignored.
- R8: A soft-reset request made while the receive queue is empty clears both queues after that edge. It takes priority over any push or pop in the same cycle, and it leaves both read-data outputs unchanged. Enable inputs do not gate the soft reset.
- R9: A soft-reset request made while the receive queue holds data changes no count. After that edge, busy_err is 1 for one cycle.
- R10: A synchronous reset sets both levels to 0, tx_empty to 1, all other flags and busy_err to 0, and both read-data outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Enables push and pop on the transmit queue |
| rx_en | input | 1 | Enables push and pop on the receive queue |
| soft_rst_req | input | 1 | Request to empty both queues |
| tx_push | input | 1 | Register-side write strobe for the transmit queue |
| tx_wdata | input | WIDTH | Word to push into the transmit queue |
| tx_pop | input | 1 | Shift-side take strobe for the transmit queue |
| tx_rdata | output | WIDTH | Last word taken from the transmit queue |
| rx_push | input | 1 | Shift-side write strobe for the receive queue |
| rx_wdata | input | WIDTH | Word to push into the receive queue |
| rx_pop | input | 1 | Register-side read strobe for the receive queue |
| rx_rdata | output | WIDTH | Last word taken from the receive queue |
| tx_level | output | LVL_W | Transmit word count modulo DEPTH |
| tx_half | output | 1 | Transmit queue at least half full |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_level | output | LVL_W | Receive word count modulo DEPTH |
| rx_half | output | 1 | Receive queue at least half full |
| rx_ready | output | 1 | Receive queue full |
| busy_err | output | 1 | Pulse: soft reset refused |

## Verification
A wrong pointer or count shows at the ports in one of three ways. The level field diverges from the expected value one cycle after the faulty edge. A full or empty flag switches at the wrong word. Read data taken later comes out of order or repeated. Because the reference queues are compared on every cycle, a count error is reported on the cycle after it occurs, while a corrupted storage slot is reported only when that word is popped. The wrap of the level to zero at eight words is exercised on both queues, with the full flags and receive-ready used to tell full from empty.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  typedef enum logic [1:0] {
    SR_NONE   = 2'd0,
    SR_TAKE   = 2'd1,
    SR_REFUSE = 2'd2
  } srst_act_e;

  // Threshold at which a queue reports itself half full.
  function automatic int half_mark(input int depth);
    return (depth + 1) / 2;
  endfunction

endpackage

// File: rtl/sfp_fifo_core.sv
module sfp_fifo_core #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    cnt_q,
  output logic [CW-1:0]    cnt_d
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic             is_full, is_empty, push_ok, pop_ok;

  assign is_full  = (cnt_q == CW'(DEPTH));
  assign is_empty = (cnt_q == '0);
  assign push_ok  = en && push && !is_full;
  assign pop_ok   = en && pop && !is_empty;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  // Storage: no reset, single write port, registered read for block RAM.
  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdata <= '0;
    else if (pop_ok && !flush) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_nxt;
      if (pop_ok)  rd_ptr <= rd_nxt;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (flush) begin
      cnt_d = '0;
    end else begin
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(DEPTH) && push && !pop && !flush) |=> (cnt_q == CW'(DEPTH))); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && pop && !push && !flush) |=> (cnt_q == '0)); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt_q == '0)); // R8
  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!en && !flush) |=> $stable(cnt_q)); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH)); // R2

endmodule

// File: rtl/sfp_level_flags.sv
module sfp_level_flags #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HALF = sfp_pkg::half_mark(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_d,
  output logic [AW-1:0] level_q,
  output logic          half_q,
  output logic          full_q,
  output logic          empty_q
);

  // Flags registered from the next count, so they line up with the count.
  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      half_q  <= 1'b0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      level_q <= cnt_d[AW-1:0];
      half_q  <= (cnt_d >= CW'(HALF));
      full_q  <= (cnt_d == CW'(DEPTH));
      empty_q <= (cnt_d == '0);
    end
  end

  AST_FULL_WRAPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    full_q |-> (level_q == '0)); // R2
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full_q && empty_q)); // R4
  AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (rst)
    full_q |-> half_q); // R5

endmodule

// File: rtl/sfp_srst_gate.sv
module sfp_srst_gate
  import sfp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic rx_has_data,
  output logic flush,
  output logic busy_err_q
);

  srst_act_e act;

  always_comb begin
    if (!req)             act = SR_NONE;
    else if (rx_has_data) act = SR_REFUSE;
    else                  act = SR_TAKE;
  end

  assign flush = (act == SR_TAKE);

  always_ff @(posedge clk) begin
    if (rst) busy_err_q <= 1'b0;
    else     busy_err_q <= (act == SR_REFUSE);
  end

  AST_ERR_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    busy_err_q |-> $past(req)); // R9
  AST_ERR_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (busy_err_q && !$past(req, 2)) |=> (!busy_err_q || $past(req))); // R9

endmodule

// File: rtl/sfp_fifo_pair.sv
module sfp_fifo_pair #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8,
  localparam int LVL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             soft_rst_req,
  input  logic             tx_push,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_rdata,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_wdata,
  input  logic             rx_pop,
  output logic [WIDTH-1:0] rx_rdata,
  output logic [LVL_W-1:0] tx_level,
  output logic             tx_half,
  output logic             tx_full,
  output logic             tx_empty,
  output logic [LVL_W-1:0] rx_level,
  output logic             rx_half,
  output logic             rx_ready,
  output logic             busy_err
);

  logic          flush;
  logic [CW-1:0] tx_cnt_q, tx_cnt_d, rx_cnt_q, rx_cnt_d;
  logic          rx_empty_unused;

  sfp_srst_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .req         (soft_rst_req),
    .rx_has_data (rx_cnt_q != '0),
    .flush       (flush),
    .busy_err_q  (busy_err)
  );

  sfp_fifo_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_core (
    .clk   (clk),
    .rst   (rst),
    .en    (tx_en),
    .flush (flush),
    .push  (tx_push),
    .wdata (tx_wdata),
    .pop   (tx_pop),
    .rdata (tx_rdata),
    .cnt_q (tx_cnt_q),
    .cnt_d (tx_cnt_d)
  );

  sfp_fifo_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_core (
    .clk   (clk),
    .rst   (rst),
    .en    (rx_en),
    .flush (flush),
    .push  (rx_push),
    .wdata (rx_wdata),
    .pop   (rx_pop),
    .rdata (rx_rdata),
    .cnt_q (rx_cnt_q),
    .cnt_d (rx_cnt_d)
  );

  sfp_level_flags #(.DEPTH(DEPTH)) u_tx_flags (
    .clk     (clk),
    .rst     (rst),
    .cnt_d   (tx_cnt_d),
    .level_q (tx_level),
    .half_q  (tx_half),
    .full_q  (tx_full),
    .empty_q (tx_empty)
  );

  sfp_level_flags #(.DEPTH(DEPTH)) u_rx_flags (
    .clk     (clk),
    .rst     (rst),
    .cnt_d   (rx_cnt_d),
    .level_q (rx_level),
    .half_q  (rx_half),
    .full_q  (rx_ready),
    .empty_q (rx_empty_unused)
  );

  AST_TX_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    tx_level == tx_cnt_q[LVL_W-1:0]); // R2
  AST_RX_READY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    rx_ready == (rx_cnt_q == CW'(DEPTH))); // R3
  AST_RX_EMPTY_TRACKS: assert property (@(posedge clk) disable iff (rst)
    rx_empty_unused == (rx_cnt_q == '0)); // R3
  AST_REFUSE_KEEPS_TX: assert property (@(posedge clk) disable iff (rst)
    (busy_err && !$past(tx_push) && !$past(tx_pop)) |-> $stable(tx_cnt_q)); // R9

endmodule

// File: tb/tb_sfp_fifo_pair.sv
`timescale 1ns/1ps
module tb_sfp_fifo_pair;

  localparam int W = 9;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, rx_en = 1'b0, soft_rst_req = 1'b0;
  logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [W-1:0] tx_wdata = '0, rx_wdata = '0;
  logic [W-1:0] tx_rdata, rx_rdata;
  logic [2:0] tx_level, rx_level;
  logic tx_half, tx_full, tx_empty, rx_half, rx_ready, busy_err;

  always #2 clk = ~clk;

  sfp_fifo_pair #(.WIDTH(W), .DEPTH(D)) dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en),
    .soft_rst_req(soft_rst_req),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .tx_level(tx_level), .tx_half(tx_half), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_level(rx_level), .rx_half(rx_half), .rx_ready(rx_ready), .busy_err(busy_err)
  );

  int checks = 0;
  int errors = 0;
  string phase = "R10";

  logic [W-1:0] txq[$];
  logic [W-1:0] rxq[$];
  int exp_txrd = 0, exp_rxrd = 0, exp_err = 0;

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", phase, what, act, exp);
    end
  endtask

  // Reference: behavioural queues updated with the inputs of this edge.
  task automatic model_edge();
    bit rx_has, t_pop_ok, t_push_ok, r_pop_ok, r_push_ok;
    if (rst) begin
      txq.delete(); rxq.delete();
      exp_txrd = 0; exp_rxrd = 0; exp_err = 0;
      return;
    end
    rx_has  = (rxq.size() != 0);
    exp_err = (soft_rst_req && rx_has) ? 1 : 0;
    if (soft_rst_req && !rx_has) begin
      txq.delete(); rxq.delete();
      return;
    end
    t_pop_ok  = tx_en && tx_pop && txq.size() > 0;
    t_push_ok = tx_en && tx_push && txq.size() < D;
    r_pop_ok  = rx_en && rx_pop && rxq.size() > 0;
    r_push_ok = rx_en && rx_push && rxq.size() < D;
    if (t_pop_ok)  exp_txrd = int'(txq.pop_front());
    if (t_push_ok) txq.push_back(tx_wdata);
    if (r_pop_ok)  exp_rxrd = int'(rxq.pop_front());
    if (r_push_ok) rxq.push_back(rx_wdata);
  endtask

  task automatic compare();
    int ts = txq.size();
    int rs = rxq.size();
    check("R2 tx_level", int'(tx_level), ts % 8);
    check("R4 tx_full", int'(tx_full), (ts == D) ? 1 : 0);
    check("R4 tx_empty", int'(tx_empty), (ts == 0) ? 1 : 0);
    check("R5 tx_half", int'(tx_half), (ts >= 4) ? 1 : 0);
    check("R1 tx_rdata", int'(tx_rdata), exp_txrd);
    check("R2 rx_level", int'(rx_level), rs % 8);
    check("R3 rx_ready", int'(rx_ready), (rs == D) ? 1 : 0);
    check("R5 rx_half", int'(rx_half), (rs >= 4) ? 1 : 0);
    check("R1 rx_rdata", int'(rx_rdata), exp_rxrd);
    check("R9 busy_err", int'(busy_err), exp_err);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; soft_rst_req = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    // R10: reset state
    @(negedge clk);
    rst = 1; cyc(); cyc(); rst = 0;
    phase = "R10"; cyc();

    // R1: ordered transmit traffic
    phase = "R1"; tx_en = 1; rx_en = 1;
    for (int i = 0; i < 5; i++) begin
      idle(); tx_push = 1; tx_wdata = W'(9'h100 + i * 7); cyc();
    end
    for (int i = 0; i < 5; i++) begin idle(); tx_pop = 1; cyc(); end
    idle(); cyc();

    // R3/R2: receive fill to eight, level wraps, ready flag
    phase = "R3";
    for (int i = 0; i < 8; i++) begin
      idle(); rx_push = 1; rx_wdata = W'(9'h0A5 ^ (i * 37)); cyc();
    end
    idle(); cyc();

    // R6: push into full receive queue, and push+pop while full
    phase = "R6";
    idle(); rx_push = 1; rx_wdata = 9'h1FF; cyc();
    idle(); rx_push = 1; rx_pop = 1; rx_wdata = 9'h155; cyc();
    for (int i = 0; i < 9; i++) begin idle(); rx_pop = 1; cyc(); end
    idle(); rx_pop = 1; rx_push = 1; rx_wdata = 9'h033; cyc();
    idle(); rx_pop = 1; cyc();
    idle(); tx_pop = 1; cyc();

    // R4: transmit to full then an extra push
    phase = "R4";
    for (int i = 0; i < 9; i++) begin
      idle(); tx_push = 1; tx_wdata = W'(i * 29 + 3); cyc();
    end
    idle(); cyc();

    // R7: enables low ignore strobes
    phase = "R7"; tx_en = 0; rx_en = 0;
    idle(); tx_pop = 1; rx_push = 1; rx_wdata = 9'h0F0; cyc();
    idle(); tx_push = 1; rx_pop = 1; cyc();
    tx_en = 1; rx_en = 1;

    // R9: soft reset refused while receive data remains
    phase = "R9";
    idle(); rx_push = 1; rx_wdata = 9'h123; cyc();
    idle(); soft_rst_req = 1; cyc();
    idle(); cyc();
    idle(); rx_pop = 1; cyc();

    // R8: soft reset accepted, beats a same-cycle push
    phase = "R8";
    idle(); soft_rst_req = 1; tx_push = 1; tx_wdata = 9'h0AA; cyc();
    idle(); cyc();
    idle(); tx_push = 1; tx_wdata = 9'h011; cyc();
    idle(); tx_en = 0; rx_en = 0; soft_rst_req = 1; cyc();
    tx_en = 1; rx_en = 1; idle(); cyc();

    // R5: mixed traffic across both queues
    phase = "R5";
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_push = lfsr[0] | lfsr[5];
      tx_pop  = lfsr[1] & (i > 100 ? 1'b1 : lfsr[6]);
      rx_push = lfsr[2] | (i < 200 ? lfsr[7] : 1'b0);
      rx_pop  = lfsr[3];
      tx_en   = ~(lfsr[8] & lfsr[9] & lfsr[11]);
      rx_en   = ~(lfsr[4] & lfsr[9] & lfsr[14]);
      soft_rst_req = lfsr[15] & lfsr[12] & lfsr[10];
      tx_wdata = lfsr[8:0];
      rx_wdata = lfsr[15:7];
      cyc();
    end
    idle(); tx_en = 1; rx_en = 1; cyc();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule